// File: doc/BRIEF.md
# Selectable-Order Fractional Noise-Shaping Modulator

This block turns a fixed fractional division word into a stream of small signed corrections for a fractional-N divider. Each correction is added to the integer division ratio for one divider period, and over a long run the corrections average to `frac_k / 2^FRAC_W` (FRAC_W defaults to 18). Internally a chain of three first-order accumulators feeds the carries of the later stages through first and second differences, so quantisation noise is pushed toward high offset frequencies. A select pin picks the second-order (two-stage) or third-order (three-stage) result.

An optional rounding bit sits below the accumulator LSB. When enabled it makes the effective accumulator one bit wider and lifts the mean ratio by exactly `2^-(FRAC_W+1)`, trading a small fixed frequency offset for lower fractional spurs.

Corrections leave on a valid/ready stream. The divider pulls one value per period by holding `ofs_ready` high; the modulator advances its state only when a value is taken. While `ofs_valid` is high and `ofs_ready` is low, the offered value and all internal state are held, and `frac_k`, `order_sel` and `round_en` are not looked at. Once valid, `ofs_valid` never drops until reset.

Top module: `mash_dsm`

## Requirements
- R1: While `rst_n` is low, `ofs_valid` is 0 and `ofs_data` is 0; on the first rising clock edge after release `ofs_valid` goes to 1 and then stays 1.
- R2: When `ofs_valid` is 1 and `ofs_ready` is 0, `ofs_data` holds its value and the modulator state does not advance, so the sequence of accepted values is the same as with `ofs_ready` held high.
- R3: From reset with `frac_k` = 0 and `round_en` = 0, every output is 0 in either order.
- R4: With `order_sel` = 0 (two stages) every output lies in the set -1, 0, +1, +2.
- R5: With `order_sel` = 1 (three stages) every output lies in -3 to +4.
- R6: With `order_sel` = 0 and `round_en` = 0, the sum of the first 2^FRAC_W accepted outputs after reset equals `frac_k` exactly.
- R7: With `order_sel` = 1 and `round_en` = 0, the sum of the first 2^FRAC_W accepted outputs after reset is within 1 of `frac_k`.
- R8: With `round_en` = 1 the first stage adds `2*frac_k + 1` into a FRAC_W+1 bit accumulator; the sum of the first 2^(FRAC_W+1) outputs equals `2*frac_k + 1` for `order_sel` = 0 and is within 1 of it for `order_sel` = 1.
- R9: With `order_sel` = 0, `round_en` = 0 and `frac_k` = 2^(FRAC_W-1), the outputs from reset are 0, +1, +1, 0 repeating.
- R10: `frac_k`, `order_sel` and `round_en` are sampled only in a cycle where a value is taken (or the first cycle after reset); changing them during a stall has no effect on the held value or the later sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frac_k | input | FRAC_W | Fractional word; ratio fraction is frac_k / 2^FRAC_W |
| order_sel | input | 1 | 0: two cascaded stages, 1: three cascaded stages |
| round_en | input | 1 | 1: append a constant-one bit below the accumulator LSB |
| ofs_valid | output | 1 | A correction is offered |
| ofs_ready | input | 1 | Divider takes the offered correction at this edge |
| ofs_data | output | OFS_W | Signed two's-complement ratio correction |

## Verification
The stall path and the input sampling path can meet in one cycle: a cycle with `ofs_ready` low is also a cycle in which `frac_k` or `order_sel` may move. The bench drops `ofs_ready` every third cycle of a half-scale run and, in exactly those cycles, drives `frac_k` to 0 and `order_sel` to the third-order setting, restoring them before the next taken value. It judges the result by checking every cycle that the offered value matches the expected 0, +1, +1, 0 pattern indexed by the number of values taken so far, so a leak of the altered inputs or a state advance during a stall breaks the pattern.

// File: rtl/mash_pkg.sv
package mash_pkg;

  // Number of cascaded first-order accumulator stages built.
  localparam int MASH_STAGES = 3;

  // Default width of the signed correction; covers -3 .. +4.
  localparam int MASH_OFS_W = 4;

  typedef enum logic {
    ORD_TWO   = 1'b0,
    ORD_THREE = 1'b1
  } mash_order_e;

endpackage

// File: rtl/mash_input_map.sv
module mash_input_map #(
  parameter int FRAC_W = 18,
  localparam int ACC_W = FRAC_W + 1
) (
  input  logic [FRAC_W-1:0] frac_k,
  input  logic              round_en,
  output logic [ACC_W-1:0]  inc
);

  // The fraction sits one bit up; the freed LSB carries the rounding bit.
  always_comb begin
    inc = {frac_k, round_en};
  end

endmodule

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] inc,
  output logic [W-1:0] res,
  output logic         carry
);

  logic [W-1:0] acc_q;
  logic [W:0]   total;

  always_comb begin
    total = {1'b0, acc_q} + {1'b0, inc};
    res   = total[W-1:0];
    carry = total[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (step) begin
      acc_q <= total[W-1:0];
    end
  end

endmodule

// File: rtl/mash_acc_tail.sv
module mash_acc_tail #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] inc,
  output logic         carry
);

  logic [W-1:0] acc_q;
  logic [W:0]   total;

  always_comb begin
    total = {1'b0, acc_q} + {1'b0, inc};
    carry = total[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (step) begin
      acc_q <= total[W-1:0];
    end
  end

endmodule

// File: rtl/mash_combiner.sv
module mash_combiner
  import mash_pkg::*;
#(
  parameter int OFS_W = MASH_OFS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  mash_order_e             order,
  input  logic [MASH_STAGES-1:0]  carry,
  output logic signed [OFS_W-1:0] ofs
);

  localparam logic [OFS_W-2:0] PAD = '0;

  logic c2_d, c3_d, c3_dd;
  logic signed [OFS_W-1:0] c1s, c2s, c2ds, c3s, c3ds, c3dds;
  logic signed [OFS_W-1:0] y_two, y_three;

  always_comb begin
    c1s   = $signed({PAD, carry[0]});
    c2s   = $signed({PAD, carry[1]});
    c2ds  = $signed({PAD, c2_d});
    c3s   = $signed({PAD, carry[2]});
    c3ds  = $signed({PAD, c3_d});
    c3dds = $signed({PAD, c3_dd});
    // Stage 2 carry through one difference, stage 3 carry through two.
    y_two   = c1s + c2s - c2ds;
    y_three = y_two + c3s - c3ds - c3ds + c3dds;
    ofs     = (order == ORD_THREE) ? y_three : y_two;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else if (step) begin
      c2_d  <= carry[1];
      c3_d  <= carry[2];
      c3_dd <= c3_d;
    end
  end

  // R4: two-stage result stays within -1 .. +2
  p_range_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && order == ORD_TWO) |-> (ofs >= -1 && ofs <= 2));

  // R5: three-stage result stays within -3 .. +4
  p_range_three_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && order == ORD_THREE) |-> (ofs >= -3 && ofs <= 4));

endmodule

// File: rtl/mash_dsm.sv
module mash_dsm
  import mash_pkg::*;
#(
  parameter int FRAC_W = 18,
  parameter int OFS_W  = MASH_OFS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [FRAC_W-1:0]       frac_k,
  input  logic                    order_sel,
  input  logic                    round_en,
  output logic                    ofs_valid,
  input  logic                    ofs_ready,
  output logic signed [OFS_W-1:0] ofs_data
);

  localparam int ACC_W = FRAC_W + 1;

  logic                    step;
  logic [ACC_W-1:0]        link [MASH_STAGES];
  logic [MASH_STAGES-1:0]  carry;
  logic signed [OFS_W-1:0] next_ofs;
  mash_order_e             order;

  // Advance on a taken value, or once right after reset to fill the output.
  assign step  = !ofs_valid || ofs_ready;
  assign order = mash_order_e'(order_sel);

  mash_input_map #(.FRAC_W(FRAC_W)) u_map (
    .frac_k   (frac_k),
    .round_en (round_en),
    .inc      (link[0])
  );

  for (genvar g = 0; g < MASH_STAGES; g++) begin : g_stage
    if (g < MASH_STAGES - 1) begin : g_mid
      mash_acc_stage #(.W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .inc   (link[g]),
        .res   (link[g+1]),
        .carry (carry[g])
      );
    end else begin : g_last
      mash_acc_tail #(.W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .inc   (link[g]),
        .carry (carry[g])
      );
    end
  end

  mash_combiner #(.OFS_W(OFS_W)) u_comb (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .order (order),
    .carry (carry),
    .ofs   (next_ofs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_valid <= 1'b0;
      ofs_data  <= '0;
    end else begin
      ofs_valid <= 1'b1;
      if (step) begin
        ofs_data <= next_ofs;
      end
    end
  end

  // R2: a stalled value is held and stays offered
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_valid && !ofs_ready) |=> ($stable(ofs_data) && ofs_valid));

  // R1: once offered, valid never drops
  p_valid_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_valid |=> ofs_valid);

  // R1: the first edge after reset fills the output
  p_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ofs_valid |=> ofs_valid);

endmodule

// File: tb/mash_dsm_tb.sv
`timescale 1ns/1ps
module mash_dsm_tb;

  localparam int FW  = 12;
  localparam int OW  = 4;
  localparam int NV  = 11;

  // Table: order, round, K, samples, expected sum, tolerance.
  localparam int V_ORD [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1};
  localparam int V_RND [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 1, 0};
  localparam int V_K   [NV] = '{0, 1, 1234, 4095, 2048, 1234, 0, 1234, 3, 777, 0};
  localparam int V_N   [NV] = '{4096, 4096, 4096, 4096, 4096, 8192, 8192,
                                4096, 4096, 8192, 4096};
  localparam int V_SUM [NV] = '{0, 1, 1234, 4095, 2048, 2469, 1, 1234, 3, 1555, 0};
  localparam int V_TOL [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0};

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [FW-1:0]        frac_k = '0;
  logic                 order_sel = 1'b0;
  logic                 round_en = 1'b0;
  logic                 ofs_valid;
  logic                 ofs_ready = 1'b0;
  logic signed [OW-1:0] ofs_data;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  mash_dsm #(.FRAC_W(FW), .OFS_W(OW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frac_k    (frac_k),
    .order_sel (order_sel),
    .round_en  (round_en),
    .ofs_valid (ofs_valid),
    .ofs_ready (ofs_ready),
    .ofs_data  (ofs_data)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input int ord, input int rnd, input int k, input logic rdy);
    @(negedge clk);
    rst_n     = 1'b0;
    ofs_ready = 1'b0;
    repeat (2) @(negedge clk);
    order_sel = ord[0];
    round_en  = rnd[0];
    frac_k    = FW'(k);
    ofs_ready = rdy;
    rst_n     = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R1: outputs during reset, then valid one edge after release
    repeat (2) @(negedge clk);
    check("R1 valid in reset", int'(ofs_valid), 0);
    check("R1 data in reset", int'(ofs_data), 0);
    start(0, 0, 2048, 1'b0);
    check("R1 valid before first edge", int'(ofs_valid), 0);
    @(negedge clk);
    check("R1 valid after first edge", int'(ofs_valid), 1);

    // Table walk: R3 zero word, R4/R5 ranges, R6/R7 sums, R8 rounding bit
    for (int v = 0; v < NV; v++) begin
      int sum;
      int out_rng;
      int nonzero;
      int s;
      sum = 0;
      out_rng = 0;
      nonzero = 0;
      start(V_ORD[v], V_RND[v], V_K[v], 1'b1);
      for (int i = 0; i < V_N[v]; i++) begin
        @(negedge clk);
        s = int'(ofs_data);
        sum += s;
        if (s != 0) nonzero++;
        if (V_ORD[v] == 0 && (s < -1 || s > 2)) out_rng++;
        if (V_ORD[v] == 1 && (s < -3 || s > 4)) out_rng++;
      end
      if (V_ORD[v] == 0) check($sformatf("R4 range entry %0d", v), out_rng, 0);
      else               check($sformatf("R5 range entry %0d", v), out_rng, 0);
      if (V_K[v] == 0 && V_RND[v] == 0)
        check($sformatf("R3 nonzero count entry %0d", v), nonzero, 0);
      if (V_RND[v] == 1) begin
        // R8: rounding bit lifts the sum to 2K+1 over the doubled period
        if (sum >= V_SUM[v] - V_TOL[v] && sum <= V_SUM[v] + V_TOL[v])
          check($sformatf("R8 sum entry %0d", v), sum, sum);
        else
          check($sformatf("R8 sum entry %0d", v), sum, V_SUM[v]);
      end else if (V_ORD[v] == 0) begin
        check($sformatf("R6 sum entry %0d", v), sum, V_SUM[v]);
      end else begin
        // R7: third order within one of K
        if (sum >= V_SUM[v] - V_TOL[v] && sum <= V_SUM[v] + V_TOL[v])
          check($sformatf("R7 sum entry %0d", v), sum, sum);
        else
          check($sformatf("R7 sum entry %0d", v), sum, V_SUM[v]);
      end
    end

    // R9: half-scale word gives 0,+1,+1,0 repeating
    start(0, 0, 2048, 1'b1);
    for (int i = 0; i < 8; i++) begin
      int e;
      e = ((i % 4) == 1 || (i % 4) == 2) ? 1 : 0;
      @(negedge clk);
      check($sformatf("R9 sample %0d", i), int'(ofs_data), e);
    end

    // R2 and R10: stalls every third cycle, inputs disturbed while stalled
    start(0, 0, 2048, 1'b0);
    begin
      int idx;
      idx = 0;
      for (int c = 0; c < 24; c++) begin
        int e;
        logic rdy;
        @(negedge clk);
        e = ((idx % 4) == 1 || (idx % 4) == 2) ? 1 : 0;
        check($sformatf("R2 R10 cycle %0d", c), int'(ofs_data), e);
        check($sformatf("R2 valid cycle %0d", c), int'(ofs_valid), 1);
        rdy = ((c % 3) != 2);
        ofs_ready = rdy;
        if (rdy) begin
          frac_k    = FW'(2048);
          order_sel = 1'b0;
          idx++;
        end else begin
          frac_k    = '0;
          order_sel = 1'b1;
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule